// File: doc/BRIEF.md
# Transmit Header Stripper

This block sits on the transmit word stream of a radio data path, between the parallel host bus and the sample pipeline. Each transmit block opens with a block-start marker on its first word. When metadata mode is on, the first four words of the block form a header: it is parsed and removed, and only the payload words go on. The header gives a 32-bit transmit timestamp and, in packet mode, the payload length. Two header words hold fixed check patterns, and a block whose check patterns are wrong is discarded.

Downstream logic receives the payload words with valid, first and last markers. The timestamp and the payload length appear on registered outputs, updated together with a one-cycle header-valid pulse. Words that arrive after a block's last payload word and before the next block start are discarded, and a saturating counter records how many there were. With metadata off, every word of a fixed-size block is payload.

Top module: `tx_hdr_parser`

## Requirements
- R1: After reset, outValid, outFirst, outLast, hdrValid and hdrErr are 0, and txTime, payLen and overrunCnt are 0.
- R2: A block start takes effect only on a word with inValid high. metaEn and pktMode are sampled on that word and hold for the whole block. Valid words that arrive after reset and before the first block start are dropped and are not counted.
- R3: With metaEn high, the block-start word and the next three valid words are header words 0..3 and are never forwarded. Header word 1 is the timestamp and appears on txTime.
- R4: In packet mode (pktMode high), payLen is bits [7:0] of header word 0, and exactly that many payload words are forwarded. A length of 0 forwards none.
- R5: In block mode with metaEn high, bits [7:0] of header word 0 are ignored, payLen is 512 - 4 = 508, and 508 payload words are forwarded.
- R6: With metaEn low, all 512 words of the block are forwarded, starting with the block-start word. payLen becomes 512, hdrValid stays low and txTime keeps its value.
- R7: Each forwarded word appears on outWord with outValid one cycle after it was accepted. outFirst marks the block's first payload word and outLast marks its last one.
- R8: hdrValid is a one-cycle pulse in the cycle after header word 3 is accepted. txTime and payLen change only in that cycle, or together with outFirst in R6. If the payload follows the header with no gap, hdrValid comes one cycle before the first payload output.
- R9: If header word 2 is not 0x00000000 or header word 3 is not 0xFFFFFFFF, hdrErr pulses for one cycle instead of hdrValid. txTime and payLen keep their values, and every word up to the next block start is dropped without being counted.
- R10: After a block's last payload word, each valid word that arrives before the next block start is dropped and adds one to overrunCnt, which saturates at its maximum.
- R11: A block start in the middle of a block abandons the current block: no outLast is given for it, and the start word is parsed as the first word of the new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inWord | input | 32 | Incoming transmit word |
| inValid | input | 1 | inWord carries a word this cycle |
| blockStart | input | 1 | Current word is the first of a block |
| metaEn | input | 1 | Block carries a four-word header |
| pktMode | input | 1 | Length taken from header word 0 |
| outWord | output | 32 | Forwarded payload word |
| outValid | output | 1 | outWord is valid |
| outFirst | output | 1 | First payload word of the block |
| outLast | output | 1 | Last payload word of the block |
| hdrValid | output | 1 | Header accepted pulse |
| hdrErr | output | 1 | Header check pattern mismatch pulse |
| txTime | output | 32 | Timestamp of the last accepted header |
| payLen | output | 10 | Payload length in words of the current block |
| overrunCnt | output | 16 | Saturating count of surplus words |

## Verification
The collision that matters is a block start arriving in the same cycle that a payload word of the running block would be forwarded. The restart must win, so that word is not forwarded and starts the parsing of a new header. The bench provokes this by cutting a six-word packet after three payload words with a new packet header. It judges the result by five forwarded words in total, a single outLast that belongs to the second packet, and a payLen and txTime taken from the second header. A second case changes the mode inputs in the middle of a block, in the cycles right after the start word, and checks that the block is still parsed in the mode that was sampled at its start.

// File: rtl/tx_hdr_pkg.sv
package tx_hdr_pkg;

  localparam int HDR_WORDS = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_DRAIN,
    ST_DROP
  } parse_st_t;

  typedef struct packed {
    logic capTime;
    logic pubHdr;
    logic pubLen;
    logic fwd;
    logic first;
    logic last;
    logic err;
    logic ovr;
  } hdr_strobe_t;

endpackage

// File: rtl/tx_hdr_ctrl.sv
module tx_hdr_ctrl
  import tx_hdr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BLOCK_WORDS = 512,
  parameter int LEN_W       = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inWord,
  input  logic              inValid,
  input  logic              blockStart,
  input  logic              metaEn,
  input  logic              pktMode,
  output hdr_strobe_t       strb,
  output logic [LEN_W-1:0]  lenVal
);

  localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(BLOCK_WORDS);
  localparam logic [LEN_W-1:0] META_LEN = LEN_W'(BLOCK_WORDS - HDR_WORDS);
  localparam bit               ONE_WORD = (BLOCK_WORDS == 1);

  parse_st_t        state, stNxt;
  logic [1:0]       hdrIdx, idxNxt;
  logic [LEN_W-1:0] remain, remNxt;
  logic [LEN_W-1:0] pendLen, pendNxt;
  logic             firstPend, firstNxt;
  logic             badAcc, badNxt;

  always_comb begin
    strb     = '0;
    stNxt    = state;
    idxNxt   = hdrIdx;
    remNxt   = remain;
    pendNxt  = pendLen;
    firstNxt = firstPend;
    badNxt   = badAcc;
    lenVal   = pendLen;
    if (inValid && blockStart) begin
      if (metaEn) begin
        stNxt   = ST_HDR;
        idxNxt  = 2'd1;
        badNxt  = 1'b0;
        pendNxt = pktMode ? LEN_W'(inWord[7:0]) : META_LEN;
      end else begin
        strb.fwd    = 1'b1;
        strb.first  = 1'b1;
        strb.last   = ONE_WORD;
        strb.pubLen = 1'b1;
        lenVal      = FULL_LEN;
        remNxt      = FULL_LEN - LEN_W'(1);
        firstNxt    = 1'b0;
        stNxt       = ONE_WORD ? ST_DRAIN : ST_PAY;
      end
    end else if (inValid) begin
      unique case (state)
        ST_HDR: begin
          unique case (hdrIdx)
            2'd1: begin
              strb.capTime = 1'b1;
              idxNxt       = 2'd2;
            end
            2'd2: begin
              badNxt = (inWord != '0);
              idxNxt = 2'd3;
            end
            default: begin
              if (badAcc || (inWord != '1)) begin
                strb.err = 1'b1;
                stNxt    = ST_DROP;
              end else begin
                strb.pubHdr = 1'b1;
                remNxt      = pendLen;
                firstNxt    = 1'b1;
                stNxt       = (pendLen == '0) ? ST_DRAIN : ST_PAY;
              end
            end
          endcase
        end
        ST_PAY: begin
          strb.fwd   = 1'b1;
          strb.first = firstPend;
          strb.last  = (remain == LEN_W'(1));
          remNxt     = remain - LEN_W'(1);
          firstNxt   = 1'b0;
          if (remain == LEN_W'(1)) stNxt = ST_DRAIN;
        end
        ST_DRAIN: strb.ovr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      hdrIdx    <= '0;
      remain    <= '0;
      pendLen   <= '0;
      firstPend <= 1'b0;
      badAcc    <= 1'b0;
    end else begin
      state     <= stNxt;
      hdrIdx    <= idxNxt;
      remain    <= remNxt;
      pendLen   <= pendNxt;
      firstPend <= firstNxt;
      badAcc    <= badNxt;
    end
  end

  // R9: a block rejected for its header forwards and counts nothing until restart
  a_r9_drop_silent : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DROP && !(inValid && blockStart)) |-> (!strb.fwd && !strb.ovr));

  // R10: the payload phase always has words left to send
  a_r10_pay_nonzero : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PAY) |-> (remain != '0));

  // R3: header words are never forwarded
  a_r3_hdr_not_fwd : assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HDR && !blockStart) |-> !strb.fwd);

endmodule

// File: rtl/tx_hdr_data.sv
module tx_hdr_data
  import tx_hdr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 10,
  parameter int OVR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inWord,
  input  hdr_strobe_t       strb,
  input  logic [LEN_W-1:0]  lenVal,
  output logic [DATA_W-1:0] outWord,
  output logic              outValid,
  output logic              outFirst,
  output logic              outLast,
  output logic              hdrValid,
  output logic              hdrErr,
  output logic [DATA_W-1:0] txTime,
  output logic [LEN_W-1:0]  payLen,
  output logic [OVR_W-1:0]  overrunCnt
);

  logic [DATA_W-1:0] timeShadow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outWord    <= '0;
      outValid   <= 1'b0;
      outFirst   <= 1'b0;
      outLast    <= 1'b0;
      hdrValid   <= 1'b0;
      hdrErr     <= 1'b0;
      txTime     <= '0;
      payLen     <= '0;
      overrunCnt <= '0;
      timeShadow <= '0;
    end else begin
      outValid <= strb.fwd;
      outFirst <= strb.fwd & strb.first;
      outLast  <= strb.fwd & strb.last;
      hdrValid <= strb.pubHdr;
      hdrErr   <= strb.err;
      if (strb.fwd) outWord <= inWord;
      if (strb.capTime) timeShadow <= inWord;
      if (strb.pubHdr) begin
        txTime <= timeShadow;
        payLen <= lenVal;
      end
      if (strb.pubLen) payLen <= lenVal;
      if (strb.ovr && (overrunCnt != '1)) overrunCnt <= overrunCnt + OVR_W'(1);
    end
  end

  // R7: markers only accompany a valid word
  a_r7_last_valid : assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);
  a_r7_first_valid : assert property (@(posedge clk) disable iff (!rstN)
    outFirst |-> outValid);

  // R9: accept and reject never signalled together
  a_r9_err_excl : assert property (@(posedge clk) disable iff (!rstN)
    !(hdrValid && hdrErr));

  // R8: published header fields move only with their pulse
  a_r8_time_moves : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txTime) |-> hdrValid);
  a_r8_len_moves : assert property (@(posedge clk) disable iff (!rstN)
    !$stable(payLen) |-> (hdrValid || outFirst));

  // R10: the overrun count never goes down
  a_r10_ovr_monotonic : assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (overrunCnt >= $past(overrunCnt)));

endmodule

// File: rtl/tx_hdr_parser.sv
module tx_hdr_parser
  import tx_hdr_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BLOCK_WORDS = 512,
  parameter int OVR_W       = 16,
  localparam int LEN_RAW    = $clog2(BLOCK_WORDS + 1),
  localparam int LEN_W      = (LEN_RAW > 8) ? LEN_RAW : 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inWord,
  input  logic              inValid,
  input  logic              blockStart,
  input  logic              metaEn,
  input  logic              pktMode,
  output logic [DATA_W-1:0] outWord,
  output logic              outValid,
  output logic              outFirst,
  output logic              outLast,
  output logic              hdrValid,
  output logic              hdrErr,
  output logic [DATA_W-1:0] txTime,
  output logic [LEN_W-1:0]  payLen,
  output logic [OVR_W-1:0]  overrunCnt
);

  hdr_strobe_t      strb;
  logic [LEN_W-1:0] lenVal;

  tx_hdr_ctrl #(
    .DATA_W(DATA_W), .BLOCK_WORDS(BLOCK_WORDS), .LEN_W(LEN_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid),
    .blockStart(blockStart), .metaEn(metaEn), .pktMode(pktMode),
    .strb(strb), .lenVal(lenVal)
  );

  tx_hdr_data #(
    .DATA_W(DATA_W), .LEN_W(LEN_W), .OVR_W(OVR_W)
  ) data_i (
    .clk(clk), .rstN(rstN), .inWord(inWord), .strb(strb), .lenVal(lenVal),
    .outWord(outWord), .outValid(outValid), .outFirst(outFirst),
    .outLast(outLast), .hdrValid(hdrValid), .hdrErr(hdrErr),
    .txTime(txTime), .payLen(payLen), .overrunCnt(overrunCnt)
  );

endmodule

// File: tb/tx_hdr_parser_tb_top.sv
module tx_hdr_parser_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] inWord = '0;
  logic        inValid = 1'b0;
  logic        blockStart = 1'b0;
  logic        metaEn = 1'b0;
  logic        pktMode = 1'b0;
  logic [31:0] outWord;
  logic        outValid, outFirst, outLast, hdrValid, hdrErr;
  logic [31:0] txTime;
  logic [9:0]  payLen;
  logic [15:0] overrunCnt;

  always #10 clk = ~clk;

  tx_hdr_parser dut_i (
    .clk(clk), .rstN(rstN), .inWord(inWord), .inValid(inValid),
    .blockStart(blockStart), .metaEn(metaEn), .pktMode(pktMode),
    .outWord(outWord), .outValid(outValid), .outFirst(outFirst),
    .outLast(outLast), .hdrValid(hdrValid), .hdrErr(hdrErr),
    .txTime(txTime), .payLen(payLen), .overrunCnt(overrunCnt)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // output monitor
  logic [31:0] capW [0:2047];
  int nOut = 0, nLast = 0, nHdr = 0, nErr = 0, cyc = 0;
  int firstPos = -1, lastPos = -1, hdrCyc = -1, firstCyc = -1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN && outValid) begin
      capW[nOut] <= outWord;
      if (outFirst) begin firstPos <= nOut; firstCyc <= cyc; end
      if (outLast) begin lastPos <= nOut; nLast <= nLast + 1; end
      nOut <= nOut + 1;
    end
    if (rstN && hdrValid) begin nHdr <= nHdr + 1; hdrCyc <= cyc; end
    if (rstN && hdrErr) nErr <= nErr + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic putWord(input logic [31:0] w, input bit bs);
    inWord = w; inValid = 1'b1; blockStart = bs;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0; blockStart = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendHdr(input logic [7:0] len, input logic [31:0] ts,
                         input logic [31:0] w2, input logic [31:0] w3);
    putWord({24'h100000, len}, 1'b1);
    putWord(ts, 1'b0);
    putWord(w2, 1'b0);
    putWord(w3, 1'b0);
  endtask

  task automatic sendPay(input int n, input logic [7:0] tag);
    for (int i = 0; i < n; i++) putWord({tag, 24'(i)}, 1'b0);
  endtask

  task automatic t_reset;
    check("R1 outValid", 32'(outValid), 0);
    check("R1 hdrValid", 32'(hdrValid), 0);
    check("R1 hdrErr", 32'(hdrErr), 0);
    check("R1 txTime", txTime, 0);
    check("R1 payLen", 32'(payLen), 0);
    check("R1 overrunCnt", 32'(overrunCnt), 0);
  endtask

  task automatic t_stray;
    int b = nOut;
    metaEn = 1'b1; pktMode = 1'b1;
    sendPay(3, 8'h11);
    idle(3);
    check("R2 stray words not forwarded", 32'(nOut - b), 0);
    check("R2 stray words not counted", 32'(overrunCnt), 0);
  endtask

  task automatic t_packet;
    int b = nOut;
    sendHdr(8'd5, 32'h12345678, 32'h0, 32'hFFFFFFFF);
    sendPay(5, 8'hA1);
    putWord(32'h0BAD0001, 1'b0);
    putWord(32'h0BAD0002, 1'b0);
    idle(3);
    check("R4 packet words forwarded", 32'(nOut - b), 5);
    check("R4 packet payLen", 32'(payLen), 5);
    check("R3 timestamp", txTime, 32'h12345678);
    check("R7 first word", capW[b], {8'hA1, 24'd0});
    check("R7 last word", capW[b + 4], {8'hA1, 24'd4});
    check("R7 first position", 32'(firstPos), 32'(b));
    check("R7 last position", 32'(lastPos), 32'(b + 4));
    check("R8 hdrValid one cycle before first", 32'(firstCyc - hdrCyc), 1);
    check("R10 overrun count", 32'(overrunCnt), 2);
  endtask

  task automatic t_zero_len;
    int b = nOut, h = nHdr;
    sendHdr(8'd0, 32'hCAFE0001, 32'h0, 32'hFFFFFFFF);
    inValid = 1'b0; blockStart = 1'b1; @(negedge clk);
    sendPay(2, 8'hB2);
    idle(3);
    check("R4 zero length forwards none", 32'(nOut - b), 0);
    check("R4 zero length header pulse", 32'(nHdr - h), 1);
    check("R4 zero length payLen", 32'(payLen), 0);
    check("R2 start without valid ignored", 32'(overrunCnt), 4);
  endtask

  task automatic t_block_meta;
    int b = nOut;
    pktMode = 1'b0;
    sendHdr(8'h37, 32'h00000190, 32'h0, 32'hFFFFFFFF);
    sendPay(508, 8'hC3);
    idle(3);
    check("R5 block words forwarded", 32'(nOut - b), 508);
    check("R5 block payLen", 32'(payLen), 508);
    check("R5 last position", 32'(lastPos), 32'(b + 507));
    check("R5 last word", capW[b + 507], {8'hC3, 24'd507});
    check("R3 block timestamp", txTime, 32'h190);
  endtask

  task automatic t_no_meta;
    int b = nOut, h = nHdr;
    metaEn = 1'b0;
    putWord(32'hD4FFFF00, 1'b1);
    sendPay(511, 8'hD4);
    idle(3);
    metaEn = 1'b1;
    check("R6 all words forwarded", 32'(nOut - b), 512);
    check("R6 start word is payload", capW[b], 32'hD4FFFF00);
    check("R6 first position", 32'(firstPos), 32'(b));
    check("R6 last position", 32'(lastPos), 32'(b + 511));
    check("R6 payLen", 32'(payLen), 512);
    check("R6 no header pulse", 32'(nHdr - h), 0);
    check("R6 txTime unchanged", txTime, 32'h190);
  endtask

  task automatic t_bad(input logic [31:0] w2, input logic [31:0] w3, input string tag);
    int b = nOut, h = nHdr, e = nErr;
    pktMode = 1'b1;
    sendHdr(8'd3, 32'h0000DEAD, w2, w3);
    sendPay(3, 8'hE5);
    idle(3);
    check({"R9 error pulse ", tag}, 32'(nErr - e), 1);
    check({"R9 no accept ", tag}, 32'(nHdr - h), 0);
    check({"R9 payload dropped ", tag}, 32'(nOut - b), 0);
    check({"R9 payLen kept ", tag}, 32'(payLen), 512);
    check({"R9 txTime kept ", tag}, txTime, 32'h190);
    check({"R9 not counted ", tag}, 32'(overrunCnt), 4);
  endtask

  task automatic t_abort;
    int b = nOut, l = nLast;
    sendHdr(8'd6, 32'h00000111, 32'h0, 32'hFFFFFFFF);
    sendPay(3, 8'hF6);
    sendHdr(8'd2, 32'h00000222, 32'h0, 32'hFFFFFFFF);
    sendPay(2, 8'hF7);
    idle(3);
    check("R11 words forwarded", 32'(nOut - b), 5);
    check("R11 single last", 32'(nLast - l), 1);
    check("R11 last is second packet", 32'(lastPos), 32'(b + 4));
    check("R11 second payLen", 32'(payLen), 2);
    check("R11 second timestamp", txTime, 32'h222);
    check("R11 start word not forwarded", capW[b + 3], {8'hF7, 24'd0});
  endtask

  task automatic t_mode_latch;
    int b = nOut, h = nHdr;
    pktMode = 1'b1; metaEn = 1'b1;
    putWord({24'h100000, 8'd3}, 1'b1);
    metaEn = 1'b0; pktMode = 1'b0;
    putWord(32'h00000333, 1'b0);
    putWord(32'h0, 1'b0);
    putWord(32'hFFFFFFFF, 1'b0);
    sendPay(3, 8'h99);
    idle(3);
    check("R2 mode held: forwarded", 32'(nOut - b), 3);
    check("R2 mode held: payLen", 32'(payLen), 3);
    check("R2 mode held: header pulse", 32'(nHdr - h), 1);
    check("R2 mode held: first word", capW[b], {8'h99, 24'd0});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset;
    t_stray;
    t_packet;
    t_zero_len;
    t_block_meta;
    t_no_meta;
    t_bad(32'h00000001, 32'hFFFFFFFF, "word2");
    t_bad(32'h00000000, 32'hFFFFFFFE, "word3");
    t_abort;
    t_mode_latch;
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule